// File: doc/BRIEF.md
# Serial Bit-Change Detector

This block watches a one-bit serial stream, sampled on every rising clock edge, and raises `detect` whenever the newest sampled bit differs from the one sampled before it. In other words, it reports a 0-then-1 or a 1-then-0 pair in the last two samples. Because successive pairs overlap, a stream that alternates on every clock keeps `detect` high for as long as the alternation lasts.

A build parameter chooses how the flag is produced. In the state-decoded style, five states remember the last bit and whether it completed a change, and `detect` is decoded from the state register alone. In the registered-transition style, three states remember only the last bit. The flag is worked out on the transition arc and stored in its own flip-flop, so the output comes straight from a register. Either way the flag is valid during the cycle that follows the edge that sampled the completing bit, so the two builds look the same at the ports.

A synchronous, active-high reset returns the machine to a state that holds no history, and it clears the flag.

Top module: `bit_change_detector`

## Requirements
- R1: In the cycle after a rising edge that samples `rst` high, `detect` is 0.
- R2: The first bit sampled after reset is released never raises `detect`, whatever its value.
- R3: When a 1 is sampled and the previous sampled bit (since reset) was 0, `detect` is 1 during the following cycle.
- R4: When a 0 is sampled and the previous sampled bit (since reset) was 1, `detect` is 1 during the following cycle.
- R5: When the sampled bit equals the previous sampled bit, `detect` is 0 during the following cycle.
- R6: Pairs overlap, so a stream that changes value on every clock holds `detect` at 1 on every cycle after the second bit.
- R7: `STYLE` = 0 (state-decoded) and `STYLE` = 1 (registered-transition) give the same `detect` sequence for the same `rst`/`din` sequence.
- R8: A reset asserted in mid-stream discards the remembered bit, so the bit sampled before the reset is never compared with the bit sampled after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit, sampled on every rising edge |
| detect | output | 1 | High for one cycle per sampled bit that differs from its predecessor |

## Verification
The bound checker keeps its own record of the last sampled bit, and on every cycle it checks the cleared flag after reset, the silence on the first bit, the flag on rising and falling pairs, and the low flag on repeated bits. It cannot show that the two build styles agree, because each build holds only one style. The bench therefore builds both styles side by side. It drives fixed runs, an alternating burst, a reset in mid-stream and a long pseudo-random stream, and compares both outputs against a queue-based model on every clock.

// File: rtl/bit_change_detector_pkg.sv
package bit_change_detector_pkg;

    localparam int unsigned STYLE_STATE_DECODED = 0;
    localparam int unsigned STYLE_REG_TRANSITION = 1;

    localparam int unsigned DEC_STATE_W = 3;
    localparam int unsigned TRN_STATE_W = 2;

    typedef enum logic [DEC_STATE_W-1:0] {
        DEC_EMPTY = 3'd0,
        DEC_LOW   = 3'd1,
        DEC_HIGH  = 3'd2,
        DEC_ROSE  = 3'd3,
        DEC_FELL  = 3'd4
    } dec_state_e;

    typedef enum logic [TRN_STATE_W-1:0] {
        TRN_EMPTY = 2'd0,
        TRN_LOW   = 2'd1,
        TRN_HIGH  = 2'd2
    } trn_state_e;

    typedef struct packed {
        dec_state_e st;
    } dec_regs_t;

    typedef struct packed {
        trn_state_e st;
        logic       flag;
    } trn_regs_t;

endpackage

// File: rtl/bcd_state_decoded.sv
module bcd_state_decoded
    import bit_change_detector_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic detect
);

    dec_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            DEC_EMPTY: r_d.st = din ? DEC_HIGH : DEC_LOW;
            DEC_LOW:   r_d.st = din ? DEC_ROSE : DEC_LOW;
            DEC_HIGH:  r_d.st = din ? DEC_HIGH : DEC_FELL;
            DEC_ROSE:  r_d.st = din ? DEC_HIGH : DEC_FELL;
            DEC_FELL:  r_d.st = din ? DEC_ROSE : DEC_LOW;
            default:   r_d.st = DEC_EMPTY;
        endcase
        if (rst) begin
            r_d.st = DEC_EMPTY;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    // Output is a pure decode of the state register; unused codes read as 0.
    always_comb begin
        case (r_q.st)
            DEC_ROSE, DEC_FELL: detect = 1'b1;
            default:            detect = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcd_reg_transition.sv
module bcd_reg_transition
    import bit_change_detector_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic detect
);

    trn_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.flag = 1'b0;
        case (r_q.st)
            TRN_EMPTY: begin
                r_d.st = din ? TRN_HIGH : TRN_LOW;
            end
            TRN_LOW: begin
                r_d.st   = din ? TRN_HIGH : TRN_LOW;
                r_d.flag = din;
            end
            TRN_HIGH: begin
                r_d.st   = din ? TRN_HIGH : TRN_LOW;
                r_d.flag = ~din;
            end
            default: begin
                r_d.st = TRN_EMPTY;
            end
        endcase
        if (rst) begin
            r_d.st   = TRN_EMPTY;
            r_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign detect = r_q.flag;

endmodule

// File: rtl/bit_change_detector.sv
module bit_change_detector
    import bit_change_detector_pkg::*;
#(
    parameter int unsigned STYLE = STYLE_STATE_DECODED
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic detect
);

    generate
        if (STYLE == STYLE_REG_TRANSITION) begin : g_trn
            bcd_reg_transition u_core (
                .clk    (clk),
                .rst    (rst),
                .din    (din),
                .detect (detect)
            );
        end else begin : g_dec
            bcd_state_decoded u_core (
                .clk    (clk),
                .rst    (rst),
                .din    (din),
                .detect (detect)
            );
        end
    endgenerate

endmodule

// File: rtl/bit_change_detector_chk.sv
module bit_change_detector_chk (
    input logic clk,
    input logic rst,
    input logic din,
    input logic detect
);

    logic have_q;
    logic last_q;
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            have_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            have_q <= 1'b1;
            last_q <= din;
        end
    end

    // R1: flag cleared after a sampled reset
    always_ff @(posedge clk) begin
        if (rst_q == 1'b1) begin
            a_r1_reset_clears: assert (detect == 1'b0);
        end
    end

    a_r2_first_bit_quiet: assert property (@(posedge clk) disable iff (rst)
        (!have_q) |=> !detect);

    a_r3_rise_flags: assert property (@(posedge clk) disable iff (rst)
        (have_q && !last_q && din) |=> detect);

    a_r4_fall_flags: assert property (@(posedge clk) disable iff (rst)
        (have_q && last_q && !din) |=> detect);

    a_r5_repeat_quiet: assert property (@(posedge clk) disable iff (rst)
        (have_q && (last_q == din)) |=> !detect);

endmodule

bind bit_change_detector bit_change_detector_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .detect (detect)
);

// File: tb/bit_change_detector_test.sv
`timescale 1ns/1ps
module bit_change_detector_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic det_dec, det_trn;

    int checks = 0;
    int errors = 0;
    bit hist[$];
    bit exp_q = 1'b0;
    string kind = "R1";

    always #5 clk = ~clk;

    bit_change_detector #(.STYLE(0)) uut (
        .clk(clk), .rst(rst), .din(din), .detect(det_dec));

    bit_change_detector #(.STYLE(1)) uut_trn (
        .clk(clk), .rst(rst), .din(din), .detect(det_trn));

    task automatic check_bit(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one sample, update the model at the edge, compare after it.
    task automatic step(bit r, bit b, string scen);
        rst = r;
        din = b;
        @(posedge clk);
        if (r) begin
            hist.delete();
            exp_q = 1'b0;
            kind  = "R1";
        end else begin
            hist.push_back(b);
            if (hist.size() == 1) begin
                exp_q = 1'b0;
                kind  = (scen == "R8") ? "R8" : "R2";
            end else begin
                exp_q = (hist[hist.size()-1] != hist[hist.size()-2]);
                if (!exp_q)                      kind = "R5";
                else if (hist[hist.size()-1])    kind = "R3";
                else                             kind = "R4";
            end
            if (hist.size() > 4) void'(hist.pop_front());
        end
        @(negedge clk);
        check_bit({kind, "/", scen, " state-decoded"}, det_dec, exp_q);
        check_bit({kind, "/", scen, " reg-transition"}, det_trn, exp_q);
        check_bit({"R7 styles agree/", scen}, det_dec, det_trn);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R1");
        // R2 first bit 1, then R5/R3/R4 runs
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b1, "R5");
        step(1'b0, 1'b0, "R4");
        step(1'b0, 1'b0, "R5");
        step(1'b0, 1'b0, "R5");
        step(1'b0, 1'b1, "R3");
        step(1'b0, 1'b1, "R5");
        // R6 alternating burst
        for (int i = 0; i < 12; i++) step(1'b0, i[0], "R6");
        // R8 reset in mid-stream: last bit 1, reset, then 0 must not flag
        step(1'b0, 1'b1, "R8");
        step(1'b1, 1'b0, "R1");
        step(1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, "R3");
        step(1'b1, 1'b1, "R1");
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, "R4");
        // pseudo-random stream with occasional resets
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step((lfsr[7:0] == 8'h5A), lfsr[0], "rand");
        end
        finish_run();
    end

endmodule